// File: doc/BRIEF.md
# Hub Timestamp Packet Delta Adjuster

This block sits in a hub between the upstream receive path and the downstream transmit path for isochronous timestamp packets. It holds one packet at a time. For each packet it measures how long the packet waits inside the hub. When the downstream transmitter reports that it is actually starting to send the packet, the block rewrites the delta and correction fields. The new values come from the measured wait, the upstream link delay and the configured hub delay. The block then recomputes the header CRC-16 one bit per clock and offers the rewritten header downstream.

A packet that arrives with its delayed flag set is forwarded untouched, CRC included. Otherwise the new delta is clamped into 0..DELTA_MAX. If the computed value is negative, its magnitude moves into the correction field.

Both packet interfaces are valid/ready. A header is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the outgoing header has been taken. The outgoing header is presented with `out_valid` and is held steady until `out_ready` is sampled high. `tx_start`, `time_tick`, `link_delay` and `hub_delay` are plain control pins.

Top module: `tsp_delta_adjust`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A header is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` stays 0 from that edge until the edge on which `out_valid` and `out_ready` are both high. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R3: A header accepted with `in_delayed`=1 appears on the outputs one edge later with every field unchanged, `out_crc` included, and no `tx_start` is needed.
- R4: The residence count is cleared on the acceptance edge. It then counts the edges with `time_tick` high that come after acceptance and before the edge that samples `tx_start`. It saturates at 2^RES_W-1 rather than wrapping.
- R5: For a header with the delayed flag clear, the signed candidate is `link_delay + in_delta + residence - hub_delay - in_corr`. `out_interval` equals `in_interval`.
- R6: If 0 <= candidate < DELTA_MAX (7500 by default), then `out_delta` equals the candidate and `out_corr` is 0. A candidate of exactly 0 gives 0 and 0.
- R7: If the candidate is DELTA_MAX or more, `out_delta` is DELTA_MAX and `out_corr` is 0.
- R8: If the candidate is negative, `out_delta` is 0 and `out_corr` is the candidate's magnitude, saturated at 0xFFFF.
- R9: `out_crc` is computed over the 48-bit header {out_corr[15:0], 4'b0, delayed bit, out_delta[12:0], out_interval[13:0]}. Bits are taken from bit 47 down to bit 0. The polynomial is 0x100B, the register starts at 0xFFFF, and the result is inverted. On this path `out_delayed` is 0.
- R10: On the rewrite path `out_valid` rises on the 49th edge after the edge that samples `tx_start`. `tx_start` has no effect unless a header is waiting for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_tick | input | 1 | Timing clock enable that advances the residence count |
| in_valid | input | 1 | Received header valid |
| in_ready | output | 1 | Block can accept a header |
| in_interval | input | 14 | Received bus interval number |
| in_delta | input | 13 | Received delta field |
| in_corr | input | 16 | Received correction field |
| in_delayed | input | 1 | Received delayed flag |
| in_crc | input | 16 | Received header CRC |
| link_delay | input | LINK_W | Measured upstream link delay |
| hub_delay | input | LINK_W | Configured hub delay |
| tx_start | input | 1 | Downstream transmission of the held header starts now |
| out_valid | output | 1 | Outgoing header valid |
| out_ready | input | 1 | Downstream accepts the header |
| out_interval | output | 14 | Outgoing bus interval number |
| out_delta | output | 13 | Outgoing delta field |
| out_corr | output | 16 | Outgoing correction field |
| out_delayed | output | 1 | Outgoing delayed flag |
| out_crc | output | 16 | Outgoing header CRC |

## Verification
The bench targets the three clamp regions and the exact-zero boundary. It also checks that a very negative candidate saturates the correction field, where a narrower design would leak a truncated magnitude. Residence is checked with the tick held off, with it on, and beyond the counter's range. A counter that wrapped would give a small delta, and one latched at queue time would ignore the wait. The bench also checks a delayed packet whose CRC must survive untouched, a stray `tx_start` with nothing queued, and a stalled `out_ready`. A design with a fault in any of these would produce a wrong field, a wrong CRC or a shifted latency, or it would accept a second header while busy.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int INTERVAL_W = 14;
  localparam int DELTA_W    = 13;
  localparam int CORR_W     = 16;
  localparam int CRC_W      = 16;
  localparam int PAD_W      = 4;
  localparam int HDR_W      = CORR_W + PAD_W + 1 + DELTA_W + INTERVAL_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h100B;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CRC, ST_OUT} state_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/tsp_res_counter.sv
module tsp_res_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (clr)             count <= '0;
    else if (en && count != CMAX) count <= count + 1'b1;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && count == CMAX) |=> count == CMAX);

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/tsp_delta_calc.sv
module tsp_delta_calc
  import tsp_pkg::*;
#(
  parameter int RES_W     = 16,
  parameter int LINK_W    = 16,
  parameter int DELTA_MAX = 7500
) (
  input  logic [LINK_W-1:0]  link_delay,
  input  logic [LINK_W-1:0]  hub_delay,
  input  logic [RES_W-1:0]   residence,
  input  logic [DELTA_W-1:0] rx_delta,
  input  logic [CORR_W-1:0]  rx_corr,
  output logic [DELTA_W-1:0] tx_delta,
  output logic [CORR_W-1:0]  tx_corr
);
  localparam int BASE_W = (RES_W > LINK_W) ? RES_W : LINK_W;
  localparam int WIDE_W = (BASE_W > CORR_W) ? BASE_W : CORR_W;
  localparam int CAND_W = WIDE_W + 4;
  localparam logic signed [CAND_W-1:0] LIMIT    = CAND_W'(DELTA_MAX);
  localparam logic signed [CAND_W-1:0] CORR_TOP = CAND_W'((1 << CORR_W) - 1);

  logic signed [CAND_W-1:0] cand;
  logic signed [CAND_W-1:0] mag;

  always_comb begin
    cand = CAND_W'(link_delay) + CAND_W'(rx_delta) + CAND_W'(residence)
         - CAND_W'(hub_delay) - CAND_W'(rx_corr);
    mag  = -cand;
    if (cand < 0) begin
      tx_delta = '0;
      tx_corr  = (mag > CORR_TOP) ? '1 : mag[CORR_W-1:0];
    end else if (cand >= LIMIT) begin
      tx_delta = DELTA_W'(DELTA_MAX);
      tx_corr  = '0;
    end else begin
      tx_delta = cand[DELTA_W-1:0];
      tx_corr  = '0;
    end
  end

  always_comb begin
    // R7
    delta_range_chk: assert (tx_delta <= DELTA_W'(DELTA_MAX));
    // R8
    corr_excl_chk: assert (tx_corr == '0 || tx_delta == '0);
  end
endmodule

// File: rtl/tsp_crc16_serial.sv
module tsp_crc16_serial
  import tsp_pkg::*;
#(
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              done,
  output logic [CRC_W-1:0]  crc
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [CRC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;
  logic              busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      acc   <= CRC_INIT;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      shreg <= data;
      acc   <= CRC_INIT;
      cnt   <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (busy) begin
      acc   <= crc_step(acc, shreg[DATA_W-1]);
      shreg <= {shreg[DATA_W-2:0], 1'b0};
      cnt   <= cnt + 1'b1;
      if (cnt == CNT_W'(DATA_W - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign crc = ~acc;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tsp_delta_adjust.sv
module tsp_delta_adjust
  import tsp_pkg::*;
#(
  parameter int RES_W     = 16,
  parameter int LINK_W    = 16,
  parameter int DELTA_MAX = 7500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  time_tick,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [INTERVAL_W-1:0] in_interval,
  input  logic [DELTA_W-1:0]    in_delta,
  input  logic [CORR_W-1:0]     in_corr,
  input  logic                  in_delayed,
  input  logic [CRC_W-1:0]      in_crc,
  input  logic [LINK_W-1:0]     link_delay,
  input  logic [LINK_W-1:0]     hub_delay,
  input  logic                  tx_start,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [INTERVAL_W-1:0] out_interval,
  output logic [DELTA_W-1:0]    out_delta,
  output logic [CORR_W-1:0]     out_corr,
  output logic                  out_delayed,
  output logic [CRC_W-1:0]      out_crc
);
  state_e state;
  logic   accept, fire;
  logic [RES_W-1:0]   residence;
  logic [DELTA_W-1:0] new_delta;
  logic [CORR_W-1:0]  new_corr;
  logic               crc_done;
  logic [CRC_W-1:0]   crc_val;
  logic [HDR_W-1:0]   crc_data;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign fire      = (state == ST_WAIT) && tx_start;
  assign crc_data  = {new_corr, {PAD_W{1'b0}}, out_delayed, new_delta, out_interval};

  tsp_res_counter #(.W(RES_W)) res_i (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(time_tick && state == ST_WAIT), .count(residence)
  );

  tsp_delta_calc #(.RES_W(RES_W), .LINK_W(LINK_W), .DELTA_MAX(DELTA_MAX)) calc_i (
    .link_delay(link_delay), .hub_delay(hub_delay), .residence(residence),
    .rx_delta(out_delta), .rx_corr(out_corr),
    .tx_delta(new_delta), .tx_corr(new_corr)
  );

  tsp_crc16_serial #(.DATA_W(HDR_W)) crc_i (
    .clk(clk), .rst_n(rst_n), .start(fire), .data(crc_data),
    .done(crc_done), .crc(crc_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      out_interval <= '0;
      out_delta    <= '0;
      out_corr     <= '0;
      out_delayed  <= 1'b0;
      out_crc      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          out_interval <= in_interval;
          out_delta    <= in_delta;
          out_corr     <= in_corr;
          out_delayed  <= in_delayed;
          out_crc      <= in_crc;
          state        <= in_delayed ? ST_OUT : ST_WAIT;
        end
        ST_WAIT: if (tx_start) begin
          out_delta <= new_delta;
          out_corr  <= new_corr;
          state     <= ST_CRC;
        end
        ST_CRC: if (crc_done) begin
          out_crc <= crc_val;
          state   <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_delta) && $stable(out_corr)
                                   && $stable(out_crc) && $stable(out_interval)));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5
  interval_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT || state == ST_CRC) |=> $stable(out_interval));
endmodule

// File: tb/tsp_delta_adjust_tb_top.sv
module tsp_delta_adjust_tb_top;
  localparam int RES_W = 10;
  localparam int DMAX  = 7500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic time_tick = 1'b0, in_valid = 1'b0, in_delayed = 1'b0, tx_start = 1'b0, out_ready = 1'b0;
  logic [13:0] in_interval = '0;
  logic [12:0] in_delta = '0;
  logic [15:0] in_corr = '0, in_crc = '0, link_delay = '0, hub_delay = '0;
  logic in_ready, out_valid, out_delayed;
  logic [13:0] out_interval;
  logic [12:0] out_delta;
  logic [15:0] out_corr, out_crc;

  int n_run = 0, n_fail = 0;
  int lat;
  bit done_flag = 0;

  always #4 clk = ~clk;

  tsp_delta_adjust #(.RES_W(RES_W), .LINK_W(16), .DELTA_MAX(DMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_interval(in_interval),
    .in_delta(in_delta), .in_corr(in_corr), .in_delayed(in_delayed), .in_crc(in_crc),
    .link_delay(link_delay), .hub_delay(hub_delay), .tx_start(tx_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_interval(out_interval),
    .out_delta(out_delta), .out_corr(out_corr), .out_delayed(out_delayed), .out_crc(out_crc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [12:0] d, input logic [13:0] iv);
    logic [47:0] h;
    logic [15:0] r;
    h = {c, 4'b0, 1'b0, d, iv};
    r = 16'hFFFF;
    for (int i = 47; i >= 0; i--) begin
      if (r[15] ^ h[i]) r = {r[14:0], 1'b0} ^ 16'h100B;
      else              r = {r[14:0], 1'b0};
    end
    return ~r;
  endfunction

  // Sends one header, waits w cycles, triggers tx, waits for out_valid (out_ready low)
  task automatic send(input logic [13:0] iv, input logic [12:0] d, input logic [15:0] c,
                      input logic dl, input logic [15:0] cr, input int w);
    @(negedge clk);
    in_interval = iv; in_delta = d; in_corr = c; in_delayed = dl; in_crc = cr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    if (!dl) begin
      repeat (w) @(negedge clk);
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      while (!out_valid && lat < 300) begin
        @(negedge clk);
        lat++;
      end
    end
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_rewrite(input string req, input logic [13:0] iv,
                                input logic [12:0] ed, input logic [15:0] ec);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " delta"}, 32'(out_delta), 32'(ed));
    check({req, " corr"}, 32'(out_corr), 32'(ec));
    check("R5 interval", 32'(out_interval), 32'(iv));
    check("R9 crc", 32'(out_crc), 32'(ref_crc(ec, ed, iv)));
    check("R9 delayed bit", 32'(out_delayed), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 in_ready", 32'(in_ready), 32'd1);
    check("R1 out_valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_in_range();
    time_tick = 1'b1; link_delay = 16'd100; hub_delay = 16'd30;
    send(14'h1234, 13'd2000, 16'd50, 1'b0, 16'h0, 20);
    check("R10 latency", 32'(lat), 32'd49);
    expect_rewrite("R6", 14'h1234, 13'd2040, 16'd0);
    release_out();
  endtask

  task automatic t_zero();
    time_tick = 1'b1; link_delay = 16'd10; hub_delay = 16'd15;
    send(14'h0007, 13'd0, 16'd0, 1'b0, 16'h0, 5);
    expect_rewrite("R6 zero", 14'h0007, 13'd0, 16'd0);
    release_out();
  endtask

  task automatic t_clamp();
    time_tick = 1'b1; link_delay = 16'd3000; hub_delay = 16'd0;
    send(14'h3FFF, 13'd7000, 16'd0, 1'b0, 16'h0, 3);
    expect_rewrite("R7", 14'h3FFF, 13'd7500, 16'd0);
    release_out();
  endtask

  task automatic t_negative();
    time_tick = 1'b1; link_delay = 16'd5; hub_delay = 16'd50;
    send(14'h0100, 13'd100, 16'd400, 1'b0, 16'h0, 10);
    expect_rewrite("R8", 14'h0100, 13'd0, 16'd335);
    release_out();
  endtask

  task automatic t_corr_sat();
    time_tick = 1'b0; link_delay = 16'd0; hub_delay = 16'hFFFF;
    send(14'h0222, 13'd0, 16'hFFFF, 1'b0, 16'h0, 2);
    expect_rewrite("R8 sat", 14'h0222, 13'd0, 16'hFFFF);
    release_out();
  endtask

  task automatic t_delayed();
    link_delay = 16'd900; hub_delay = 16'd1;
    send(14'h2A5A, 13'd4321, 16'd77, 1'b1, 16'hBEEF, 0);
    check("R3 valid", 32'(out_valid), 32'd1);
    check("R3 interval", 32'(out_interval), 32'h2A5A);
    check("R3 delta", 32'(out_delta), 32'd4321);
    check("R3 corr", 32'(out_corr), 32'd77);
    check("R3 flag", 32'(out_delayed), 32'd1);
    check("R3 crc", 32'(out_crc), 32'hBEEF);
    release_out();
  endtask

  task automatic t_no_tick();
    time_tick = 1'b0; link_delay = 16'd200; hub_delay = 16'd0;
    send(14'h0011, 13'd300, 16'd0, 1'b0, 16'h0, 30);
    expect_rewrite("R4 no tick", 14'h0011, 13'd500, 16'd0);
    release_out();
  endtask

  task automatic t_saturate();
    time_tick = 1'b1; link_delay = 16'd0; hub_delay = 16'd0;
    send(14'h0033, 13'd0, 16'd0, 1'b0, 16'h0, 1100);
    expect_rewrite("R4 sat", 14'h0033, 13'd1023, 16'd0);
    release_out();
  endtask

  task automatic t_backpressure();
    logic [12:0] d0;
    time_tick = 1'b1; link_delay = 16'd40; hub_delay = 16'd0;
    send(14'h0044, 13'd60, 16'd0, 1'b0, 16'h0, 0);
    d0 = out_delta;
    in_valid = 1'b1; in_delayed = 1'b1;
    repeat (6) @(negedge clk);
    in_valid = 1'b0; in_delayed = 1'b0;
    check("R2 stall valid", 32'(out_valid), 32'd1);
    check("R2 stall ready", 32'(in_ready), 32'd0);
    check("R2 stall delta", 32'(out_delta), 32'(d0));
    check("R2 stall value", 32'(out_delta), 32'd100);
    release_out();
    check("R2 idle after take", 32'(in_ready), 32'd1);
    check("R2 no extra pkt", 32'(out_valid), 32'd0);
  endtask

  task automatic t_stray_tx();
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 stray valid", 32'(out_valid), 32'd0);
    check("R10 stray ready", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stray_tx();
    t_in_range();
    t_zero();
    t_clamp();
    t_negative();
    t_corr_sat();
    t_delayed();
    t_no_tick();
    t_saturate();
    t_backpressure();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule